// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank SDR SDRAM. After a synchronous reset it brings the memory from power-on to a usable state. It first holds a quiet NOP condition for a stabilization period. The length of that period comes from the clock frequency and a wait time in microseconds, both set by parameters. It then issues a precharge that covers every bank. Next come a configurable number of auto-refresh commands and a load of the memory's mode register. A parameter decides which of those two phases runs first. Each command is followed by NOP spacing whose length is set by a parameter.

The mode word is built from four configuration fields: burst length, burst type, read latency and write burst mode. These fields, and the requested refresh count, are captured while reset is held. When the last command's spacing has elapsed, `init_done` rises and stays high. The pins then stay at NOP so that a normal traffic engine can take over.

Top module: `sdram_init_seq`

## Requirements
- R1: Clock enable and the data mask are driven high in reset and at every cycle afterwards.
- R2: Number the clock periods so that cycle 0 ends at the first rising edge that samples reset low. The command pins then show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, address and bank zero) for exactly W = CLK_MHZ*WAIT_US cycles, which are cycles 0 to W-1.
- R3: In cycle W the block issues a precharge to all banks: cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 high and every other address and bank bit low.
- R4: The block issues auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, address and bank zero) max(cfg_refresh_cnt, 2) times.
- R5: With MRS_FIRST=0 the refreshes follow the precharge and the mode load comes last. With MRS_FIRST=1 the mode load follows the precharge and the refreshes come last.
- R6: The mode load drives all four command pins low. Its address carries burst length in bits 2:0, burst type in bit 3, read latency in bits 6:4 and write burst mode in bit 9. Bits 7, 8, 10 and 11 and both bank bits are low.
- R7: A mode load is followed by exactly T_MRD-1 NOP cycles (T_MRD at least 2) before the next command, or before init_done rises.
- R8: A precharge is followed by T_RP-1 NOP cycles and each auto-refresh by T_RC-1 NOP cycles before the next event. Both values are at least 2.
- R9: init_done rises G cycles after the final command, where G is that command's spacing. It then stays high while the pins stay at NOP.
- R10: While reset is high, all outputs are at NOP with init_done low. Releasing reset restarts the whole sequence from R2, even when reset arrived mid-sequence.
- R11: The configuration inputs are sampled only while reset is high. Changes to them after reset is released have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_type | input | 1 | Burst type bit for the mode word |
| cfg_cas_lat | input | 3 | Read latency code for the mode word |
| cfg_wr_single | input | 1 | Write burst mode bit for the mode word |
| cfg_refresh_cnt | input | REF_W | Requested auto-refresh count (floor of two) |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | 1 | Data mask to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| init_done | output | 1 | High once initialization has finished |

## Verification
Every pin is registered once. A command decided at a rising edge therefore appears in the period that follows that edge, and the cycle numbering in R2 accounts for this. The bench builds, per instance, a queue holding one expected pin vector per cycle from the requirements. It fills the queue with W NOPs, then each command followed by its spacing NOPs, then init_done. From the reset release onward it compares every cycle at the falling edge, so each output is checked in exactly the cycle its requirement names. Both phase orders run side by side, and a reset in the middle of a refresh gap checks the restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int SD_ADDR_W = 12;
  localparam int SD_BA_W   = 2;
  localparam int MIN_REFS  = 2;
  localparam int PRE_ALL_BIT = 10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_AFTER_PRE,
    ST_AFTER_REF,
    ST_AFTER_MRS,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [2:0] burst_len;
    logic       burst_type;
    logic [2:0] cas_lat;
    logic       wr_single;
  } mode_cfg_t;

  function automatic int wait_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int eff_refs(input int req);
    return (req < MIN_REFS) ? MIN_REFS : req;
  endfunction

  // Reserved positions are left at zero; only defined fields are placed.
  function automatic logic [SD_ADDR_W-1:0] mode_word(input mode_cfg_t c);
    logic [SD_ADDR_W-1:0] w;
    w        = '0;
    w[2:0]   = c.burst_len;
    w[3]     = c.burst_type;
    w[6:4]   = c.cas_lat;
    w[9]     = c.wr_single;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= CNT_W'(RST_VAL);
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_HOLDS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R8

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  sd_cmd_e              cmd_in,
  input  logic [SD_ADDR_W-1:0] addr_in,
  input  logic [SD_BA_W-1:0]   ba_in,
  output logic                 cke,
  output logic                 dqm,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [SD_BA_W-1:0]   ba,
  output logic [SD_ADDR_W-1:0] addr
);

  sd_cmd_e              cmd_q;
  logic [SD_ADDR_W-1:0] addr_q;
  logic [SD_BA_W-1:0]   ba_q;
  logic                 cke_q;
  logic                 dqm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end else begin
      cmd_q  <= cmd_in;
      addr_q <= addr_in;
      ba_q   <= ba_in;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign ba   = ba_q;
  assign cke  = cke_q;
  assign dqm  = dqm_q;

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr_q[PRE_ALL_BIT] && ba_q == '0)); // R3
  AST_MRS_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (addr_q[8:7] == 2'b00 && addr_q[11:10] == 2'b00 && ba_q == '0)); // R6
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP)); // R8

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int WAIT_US   = 200,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int REF_W     = 4,
  parameter bit MRS_FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_burst_len,
  input  logic             cfg_burst_type,
  input  logic [2:0]       cfg_cas_lat,
  input  logic             cfg_wr_single,
  input  logic [REF_W-1:0] cfg_refresh_cnt,
  output logic             sd_cke,
  output logic             sd_dqm,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_ba,
  output logic [11:0]      sd_addr,
  output logic             init_done
);

  localparam int WAIT_CYC = wait_cycles(CLK_MHZ, WAIT_US);
  localparam int MAX_T    = max_int(max_int(WAIT_CYC, T_RP), max_int(T_RC, T_MRD));
  localparam int TMR_W    = $clog2(MAX_T + 1) + 1;

  seq_state_e           st, st_nx;
  mode_cfg_t            cfg_q;
  logic [REF_W-1:0]     ref_left;
  logic                 done_q;
  logic                 tmr_zero;
  logic                 tmr_load;
  logic [TMR_W-1:0]     tmr_val;
  sd_cmd_e              cmd_nx;
  logic [SD_ADDR_W-1:0] addr_nx;

  // Named internal events
  logic issue_pre, issue_ref, issue_mrs, finish;

  sdram_init_timer #(.CNT_W(TMR_W), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    st_nx     = st;
    issue_pre = 1'b0;
    issue_ref = 1'b0;
    issue_mrs = 1'b0;
    finish    = 1'b0;
    if (tmr_zero) begin
      unique case (st)
        ST_WAIT:      issue_pre = 1'b1;
        ST_AFTER_PRE: begin
          if (MRS_FIRST) issue_mrs = 1'b1;
          else           issue_ref = 1'b1;
        end
        ST_AFTER_REF: begin
          if (ref_left != '0) issue_ref = 1'b1;
          else if (MRS_FIRST) finish = 1'b1;
          else                issue_mrs = 1'b1;
        end
        ST_AFTER_MRS: begin
          if (MRS_FIRST) issue_ref = 1'b1;
          else           finish    = 1'b1;
        end
        default: ;
      endcase
    end
    if (issue_pre) st_nx = ST_AFTER_PRE;
    if (issue_ref) st_nx = ST_AFTER_REF;
    if (issue_mrs) st_nx = ST_AFTER_MRS;
    if (finish)    st_nx = ST_DONE;
  end

  always_comb begin
    cmd_nx  = CMD_NOP;
    addr_nx = '0;
    tmr_val = '0;
    if (issue_pre) begin
      cmd_nx               = CMD_PRE;
      addr_nx[PRE_ALL_BIT] = 1'b1;
      tmr_val              = TMR_W'(T_RP - 1);
    end else if (issue_ref) begin
      cmd_nx  = CMD_REF;
      tmr_val = TMR_W'(T_RC - 1);
    end else if (issue_mrs) begin
      cmd_nx  = CMD_MRS;
      addr_nx = mode_word(cfg_q);
      tmr_val = TMR_W'(T_MRD - 1);
    end
  end

  assign tmr_load = issue_pre | issue_ref | issue_mrs;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT;
      done_q   <= 1'b0;
      cfg_q    <= '{burst_len: cfg_burst_len, burst_type: cfg_burst_type,
                    cas_lat: cfg_cas_lat, wr_single: cfg_wr_single};
      ref_left <= REF_W'(eff_refs(int'(cfg_refresh_cnt)));
    end else begin
      st <= st_nx;
      if (issue_ref) ref_left <= ref_left - 1'b1;
      if (finish)    done_q   <= 1'b1;
    end
  end

  sdram_cmd_drive u_drive (
    .clk    (clk),
    .rst    (rst),
    .cmd_in (cmd_nx),
    .addr_in(addr_nx),
    .ba_in  ('0),
    .cke    (sd_cke),
    .dqm    (sd_dqm),
    .cs_n   (sd_cs_n),
    .ras_n  (sd_ras_n),
    .cas_n  (sd_cas_n),
    .we_n   (sd_we_n),
    .ba     (sd_ba),
    .addr   (sd_addr)
  );

  assign init_done = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !(issue_pre || issue_ref || issue_mrs)); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue_pre, issue_ref, issue_mrs, finish})); // R5
  AST_REF_AVAILABLE: assert property (@(posedge clk) disable iff (rst)
    issue_ref |-> (ref_left != '0)); // R4
  AST_REF_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (finish || (issue_mrs && !MRS_FIRST)) |-> (ref_left == '0)); // R4

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int CLK_MHZ = 125;
  localparam int WAIT_US = 2;
  localparam int W       = CLK_MHZ * WAIT_US;
  localparam int T_RP    = 3;
  localparam int T_RC    = 8;
  localparam int T_MRD   = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] c_bl = '0;
  logic       c_bt = 1'b0;
  logic [2:0] c_cl = '0;
  logic       c_wb = 1'b0;
  logic [3:0] c_rc = '0;

  logic cke0, dqm0, cs0, ras0, cas0, we0, dn0;
  logic cke1, dqm1, cs1, ras1, cas1, we1, dn1;
  logic [1:0]  ba0, ba1;
  logic [11:0] ad0, ad1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
                   .T_MRD(T_MRD), .REF_W(4), .MRS_FIRST(1'b0)) dut (
    .clk(clk), .rst(rst), .cfg_burst_len(c_bl), .cfg_burst_type(c_bt),
    .cfg_cas_lat(c_cl), .cfg_wr_single(c_wb), .cfg_refresh_cnt(c_rc),
    .sd_cke(cke0), .sd_dqm(dqm0), .sd_cs_n(cs0), .sd_ras_n(ras0), .sd_cas_n(cas0),
    .sd_we_n(we0), .sd_ba(ba0), .sd_addr(ad0), .init_done(dn0));

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
                   .T_MRD(T_MRD), .REF_W(4), .MRS_FIRST(1'b1)) dut_mf (
    .clk(clk), .rst(rst), .cfg_burst_len(c_bl), .cfg_burst_type(c_bt),
    .cfg_cas_lat(c_cl), .cfg_wr_single(c_wb), .cfg_refresh_cnt(c_rc),
    .sd_cke(cke1), .sd_dqm(dqm1), .sd_cs_n(cs1), .sd_ras_n(ras1), .sd_cas_n(cas1),
    .sd_we_n(we1), .sd_ba(ba1), .sd_addr(ad1), .init_done(dn1));

  wire [20:0] act0 = {cke0, dqm0, cs0, ras0, cas0, we0, ba0, ad0, dn0};
  wire [20:0] act1 = {cke1, dqm1, cs1, ras1, cas1, we1, ba1, ad1, dn1};

  logic [20:0] q0[$];
  logic [20:0] q1[$];
  string       t0[$];
  string       t1[$];

  // Pin vector: CKE and DQM always high (R1)
  function automatic logic [20:0] pins(input logic [3:0] cmd, input logic [11:0] a, input logic d);
    return {1'b1, 1'b1, cmd, 2'b00, a, d};
  endfunction

  task automatic push(input bit sel, input logic [20:0] v, input string tag);
    if (sel) begin q1.push_back(v); t1.push_back(tag); end
    else     begin q0.push_back(v); t0.push_back(tag); end
  endtask

  task automatic gap(input bit sel, input int g, input string tag);
    for (int i = 1; i < g; i++) push(sel, pins(4'b0111, 12'h000, 1'b0), tag);
  endtask

  task automatic build(input bit sel, input int rc, input logic [2:0] bl, input logic bt,
                       input logic [2:0] cl, input logic wb, input bit scr);
    int n;
    logic [11:0] mw;
    string mtag;
    n    = (rc < 2) ? 2 : rc;
    mw   = {2'b00, wb, 2'b00, cl, bt, bl};
    mtag = scr ? "R6 R11" : "R6";
    if (sel) mtag = {mtag, " R5"};
    for (int i = 0; i < W; i++) push(sel, pins(4'b0111, 12'h000, 1'b0), "R2 R1");
    push(sel, pins(4'b0010, 12'h400, 1'b0), "R3");
    gap(sel, T_RP, "R8");
    if (sel) begin
      push(sel, pins(4'b0000, mw, 1'b0), mtag);
      gap(sel, T_MRD, "R7");
    end
    for (int r = 0; r < n; r++) begin
      push(sel, pins(4'b0001, 12'h000, 1'b0), sel ? "R4 R5" : "R4");
      gap(sel, T_RC, "R8");
    end
    if (!sel) begin
      push(sel, pins(4'b0000, mw, 1'b0), mtag);
      gap(sel, T_MRD, "R7");
    end
    push(sel, pins(4'b0111, 12'h000, 1'b1), "R9");
  endtask

  task automatic cmp(input string who, input logic [20:0] a, input logic [20:0] e,
                     input string tag, input int cyc);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual %h expected %h", tag, who, cyc, a, e);
    end
  endtask

  task automatic run(input int rc, input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                     input logic wb, input bit scr, input int abort_at);
    int len;
    @(negedge clk);
    rst  = 1'b1;
    c_rc = 4'(rc); c_bl = bl; c_bt = bt; c_cl = cl; c_wb = wb;
    repeat (3) @(negedge clk);
    // Reset state / restart (R10)
    cmp("dut", act0, pins(4'b0111, 12'h000, 1'b0), "R10", 0);
    cmp("dut_mf", act1, pins(4'b0111, 12'h000, 1'b0), "R10", 0);
    q0.delete(); q1.delete(); t0.delete(); t1.delete();
    build(1'b0, rc, bl, bt, cl, wb, scr);
    build(1'b1, rc, bl, bt, cl, wb, scr);
    len = q0.size();
    rst = 1'b0;
    for (int c = 1; c < len + 10; c++) begin
      @(negedge clk);
      if (scr && c == 1) begin
        // Post-reset config changes must be ignored (R11)
        c_bl = ~bl; c_bt = ~bt; c_cl = ~cl; c_wb = ~wb; c_rc = 4'd9;
      end
      if (c < len) begin
        cmp("dut", act0, q0[c], t0[c], c);
        cmp("dut_mf", act1, q1[c], t1[c], c);
      end else begin
        cmp("dut", act0, q0[len-1], "R9", c);
        cmp("dut_mf", act1, q1[len-1], "R9", c);
      end
      if (abort_at != 0 && c == abort_at) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Floor of two on a request of one, refresh-first vs mode-first
    run(1, 3'd3, 1'b1, 3'd2, 1'b1, 1'b0, 0);
    // Reset during the first refresh gap (R10)
    run(5, 3'd2, 1'b0, 3'd3, 1'b0, 1'b1, W + T_RP + 3);
    // Full run with five refreshes and scrambled config after release (R11)
    run(5, 3'd1, 1'b0, 3'd3, 1'b1, 1'b1, 0);
    // Request of zero also floors to two (R4)
    run(0, 3'd7, 1'b1, 3'd1, 1'b0, 1'b0, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule